// File: doc/BRIEF.md
# Byte-Addressed I2C Register Target with Pointer Auto-Advance

This block is an I2C target that lets an external bus master read and write a register file of 128 byte-wide locations. The register storage sits next to the block and is reached through a simple port: the block presents the current register address and a one-cycle write strobe with write data, and it takes back the combinational read data of the addressed location. The incoming SCL and SDA lines are oversampled by the system clock. They pass through a two-flop synchroniser and an edge detector before the state machine sees them. The block drives the bus open-drain: one output pulls SDA low and another pulls SCL low.

A transaction begins with a start condition and a 7-bit device address followed by the read/write bit. For a write, the master then sends a sub-address byte and any number of data bytes. For a read, the master sends the sub-address, then a repeated start and the address with the read bit, and then clocks out data bytes. The master acknowledges every read byte except the last one and then ends with a stop. Bit 7 of the sub-address selects whether the register pointer moves forward by one after each data byte. Bits 6:0 give the first register. While the `busy` input is high, the block stretches the clock by holding SCL low.

The states are ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_SUBADDR, ST_SUBACK, ST_WRDATA, ST_WRACK, ST_RDDATA and ST_RDACK. A stop leads from any state to ST_IDLE, and a start or repeated start leads from any state to ST_DEVADDR. The byte-wide transitions all take place on the SCL falling edge that ends the eighth bit:
- ST_DEVADDR goes to ST_DEVACK on an address match and to ST_IDLE on a mismatch.
- ST_SUBADDR goes to ST_SUBACK.
- ST_WRDATA goes to ST_WRACK.
- ST_RDDATA goes to ST_RDACK.

The acknowledge-slot states leave on the falling edge that ends the ninth bit:
- ST_DEVACK goes to ST_SUBADDR for a write and to ST_RDDATA for a read.
- ST_SUBACK goes to ST_WRDATA.
- ST_WRACK goes back to ST_WRDATA.
- ST_RDACK goes to ST_RDDATA when the master acknowledged and to ST_IDLE when it did not.

Top module: `i2creg_target`

## Requirements
- R1: While reset is applied and right after it is released, `sda_drive_low`, `scl_hold_low` and `rf_we` are 0.
- R2: After a start, the first byte is taken as a 7-bit address (MSB first) followed by an R/W bit (0 = write, 1 = read). On a match with parameter DEV_ADDR, the block pulls SDA low in the ninth clock. On a mismatch it leaves SDA released and ignores the following bytes until the next start, and it writes no register.
- R3: The byte after an address with write is the sub-address. Bits 6:0 set the register pointer, bit 7 set to 1 enables pointer advance, and the byte is acknowledged.
- R4: Each data byte after the sub-address is acknowledged and written to the register at the pointer with a single-cycle `rf_we` pulse. The pulse is issued while SCL is low.
- R5: After a repeated start and an address with read, the block sends the byte of the register at the pointer, MSB first, with SDA changed only while SCL is low.
- R6: With advance enabled, the pointer goes up by one after each written byte and after each read byte that the master acknowledges. It wraps from 127 to 0.
- R7: With advance disabled, every data byte of the transaction uses the same register.
- R8: When the master does not acknowledge a read byte, the block releases SDA and goes idle. A later transaction after the stop works normally.
- R9: `sda_drive_low` changes only while SCL is low.
- R10: While `busy` is high during a transaction, SCL is held low from the next SCL falling edge until `busy` falls. The transfer then completes correctly.
- R11: A repeated start in the middle of a write restarts the address phase, and the new address and sub-address take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level as seen on the bus |
| sda_in | input | 1 | SDA level as seen on the bus |
| busy | input | 1 | High when the register side cannot keep up; causes clock stretching |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_hold_low | output | 1 | 1 pulls SCL low, 0 releases it |
| rf_addr | output | 7 | Register pointer, address of the register-file port |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_wdata | output | 8 | Data written when `rf_we` is high |
| rf_rdata | input | 8 | Combinational read data of the register at `rf_addr` |

## Verification
Each bus edge reaches a registered output on the third clock edge after it appears at the pins: two synchroniser flops, then the register that reacts to the detected edge. So a change of SDA drive, a write strobe or a stretch request lags the SCL edge by three cycles. The bench keeps SCL low for at least 16 cycles and high for 16 or more, so every response has settled long before it is needed. SDA is sampled eight cycles after SCL has risen on the bus. Register contents are checked after the stop, and the stretch is observed 300 cycles into the busy window, well after the stalled edge.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_SUBADDR,
        ST_SUBACK,
        ST_WRDATA,
        ST_WRACK,
        ST_RDDATA,
        ST_RDACK
    } i2cr_state_e;

    // Synchronised bus view handed to the state machine
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } i2cr_line_t;

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_raw,
    input  logic       sda_raw,
    output i2cr_line_t ln
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prv;

    assign raw = {scl_raw, sda_raw};

    // One synchroniser chain per bus line, plus one stage of history
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[SYNC_STAGES-1:0], raw[g]};
            end
        end
        assign cur[g] = chain[SYNC_STAGES-1];
        assign prv[g] = chain[SYNC_STAGES];
    end

    always_comb begin
        ln.sda      = cur[0];
        ln.scl_rise = cur[1] & ~prv[1];
        ln.scl_fall = ~cur[1] & prv[1];
        ln.start    = cur[1] & prv[1] & prv[0] & ~cur[0];
        ln.stop     = cur[1] & prv[1] & ~prv[0] & cur[0];
    end

endmodule

// File: rtl/i2cr_ptr.sv
module i2cr_ptr #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    logic adv_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            adv_en <= 1'b0;
        end else if (load) begin
            ptr    <= load_val[AW-1:0];
            adv_en <= load_val[DW-1];
        end else if (step && adv_en) begin
            ptr <= ptr + AW'(1);
        end
    end

endmodule

// File: rtl/i2cr_fsm.sv
module i2cr_fsm
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  i2cr_line_t    ln,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic          drive_low,
    output logic          hold_low,
    output logic          we,
    output logic [DW-1:0] wdata,
    output logic          ptr_load,
    output logic [DW-1:0] ptr_load_val,
    output logic          ptr_step
);
    localparam int CW = $clog2(DW + 1);

    i2cr_state_e   state, state_n;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bitcnt;
    logic          rw;
    logic          mack;
    logic          byte_done;
    logic          addr_hit;
    logic [DW-1:0] rd_shift;

    assign byte_done    = (bitcnt == CW'(DW));
    assign addr_hit     = (shreg[DW-1 -: 7] == DEV_ADDR);
    assign rd_shift     = shreg << bitcnt;
    assign ptr_load     = (state == ST_SUBADDR) && ln.scl_fall && byte_done;
    assign ptr_load_val = shreg;
    assign ptr_step     = ((state == ST_WRACK) && ln.scl_fall) ||
                          ((state == ST_RDACK) && ln.scl_rise && !ln.sda);

    // Next-state logic
    always_comb begin
        state_n = state;
        if (ln.stop) begin
            state_n = ST_IDLE;
        end else if (ln.start) begin
            state_n = ST_DEVADDR;
        end else begin
            unique case (state)
                ST_IDLE:    state_n = ST_IDLE;
                ST_DEVADDR: if (ln.scl_fall && byte_done)
                                state_n = addr_hit ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  if (ln.scl_fall)
                                state_n = rw ? ST_RDDATA : ST_SUBADDR;
                ST_SUBADDR: if (ln.scl_fall && byte_done) state_n = ST_SUBACK;
                ST_SUBACK:  if (ln.scl_fall) state_n = ST_WRDATA;
                ST_WRDATA:  if (ln.scl_fall && byte_done) state_n = ST_WRACK;
                ST_WRACK:   if (ln.scl_fall) state_n = ST_WRDATA;
                ST_RDDATA:  if (ln.scl_fall && byte_done) state_n = ST_RDACK;
                ST_RDACK:   if (ln.scl_fall)
                                state_n = mack ? ST_RDDATA : ST_IDLE;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            drive_low <= 1'b0;
            hold_low  <= 1'b0;
            we        <= 1'b0;
            wdata     <= '0;
        end else begin
            we <= 1'b0;
            if (!busy) begin
                hold_low <= 1'b0;
            end else if (ln.scl_fall && state != ST_IDLE) begin
                hold_low <= 1'b1;
            end

            if (ln.start || ln.stop) begin
                bitcnt    <= '0;
                drive_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADDR, ST_SUBADDR, ST_WRDATA: begin
                        if (ln.scl_rise && !byte_done) begin
                            shreg  <= {shreg[DW-2:0], ln.sda};
                            bitcnt <= bitcnt + CW'(1);
                        end
                        if (ln.scl_fall && byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_DEVADDR) begin
                                rw        <= shreg[0];
                                drive_low <= addr_hit;
                            end else begin
                                drive_low <= 1'b1;
                            end
                            if (state == ST_WRDATA) begin
                                we    <= 1'b1;
                                wdata <= shreg;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (ln.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg     <= rd_data;
                                drive_low <= ~rd_data[DW-1];
                            end else begin
                                drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_SUBACK, ST_WRACK: begin
                        if (ln.scl_fall) drive_low <= 1'b0;
                    end
                    ST_RDDATA: begin
                        if (ln.scl_rise && !byte_done) begin
                            bitcnt <= bitcnt + CW'(1);
                        end
                        if (ln.scl_fall) begin
                            if (byte_done) begin
                                drive_low <= 1'b0;
                            end else begin
                                drive_low <= ~rd_shift[DW-1];
                            end
                        end
                    end
                    ST_RDACK: begin
                        if (ln.scl_rise) mack <= ~ln.sda;
                        if (ln.scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                shreg     <= rd_data;
                                drive_low <= ~rd_data[DW-1];
                            end else begin
                                drive_low <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2creg_target.sv
module i2creg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         REG_AW      = 7,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              busy,
    output logic              sda_drive_low,
    output logic              scl_hold_low,
    output logic [REG_AW-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    import i2cr_pkg::*;

    i2cr_line_t        ln;
    logic              ptr_load;
    logic              ptr_step;
    logic [DATA_W-1:0] ptr_load_val;

    i2cr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ln      (ln)
    );

    i2cr_fsm #(.DEV_ADDR(DEV_ADDR), .DW(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ln           (ln),
        .busy         (busy),
        .rd_data      (rf_rdata),
        .drive_low    (sda_drive_low),
        .hold_low     (scl_hold_low),
        .we           (rf_we),
        .wdata        (rf_wdata),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .ptr_step     (ptr_step)
    );

    i2cr_ptr #(.AW(REG_AW), .DW(DATA_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .step     (ptr_step),
        .ptr      (rf_addr)
    );

endmodule

// File: rtl/i2creg_target_chk.sv
module i2creg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic busy,
    input logic sda_drive_low,
    input logic scl_hold_low,
    input logic rf_we
);
    // R9: SDA drive moves only during SCL low
    p_sda_change_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_in);

    // R4: write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R4: write strobe only while SCL is low
    p_we_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !scl_in);

    // R10: stretching starts only when busy was requested
    p_hold_from_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_low) |-> $past(busy));

    // R10: stretching ends once busy is low
    p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> !scl_hold_low);

endmodule

bind i2creg_target i2creg_target_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .busy          (busy),
    .sda_drive_low (sda_drive_low),
    .scl_hold_low  (scl_hold_low),
    .rf_we         (rf_we)
);

// File: tb/i2creg_target_bench.sv
module i2creg_target_bench;
    localparam logic [6:0] ADDR = 7'h2A;

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'h85, 8'h11, 8'h22, 8'h33},
        '{8'h10, 8'hA5, 8'h5A, 8'hC3},
        '{8'hFE, 8'h01, 8'h80, 8'hFF},
        '{8'h7F, 8'h3C, 8'h96, 8'h69}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       busy = 1'b0;
    logic       scl_bus, sda_bus;
    logic       sda_drive_low, scl_hold_low, rf_we;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic [7:0] mem [128];
    int         checks = 0;
    int         errors = 0;
    int         we_count = 0;
    int         cyc = 0;

    always #4 clk = ~clk;

    assign scl_bus  = m_scl & ~scl_hold_low;
    assign sda_bus  = m_sda & ~sda_drive_low;
    assign rf_rdata = mem[rf_addr];

    i2creg_target #(.DEV_ADDR(ADDR)) u_i2creg_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_bus),
        .sda_in        (sda_bus),
        .busy          (busy),
        .sda_drive_low (sda_drive_low),
        .scl_hold_low  (scl_hold_low),
        .rf_addr       (rf_addr),
        .rf_we         (rf_we),
        .rf_wdata      (rf_wdata),
        .rf_rdata      (rf_rdata)
    );

    // External register storage model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            we_count <= we_count + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(8);
        m_scl = 1'b1; wait_scl_high(); tick(16);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(8);
        m_scl = 1'b1; wait_scl_high(); tick(8);
        b = sda_bus; tick(8);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; tick(8);
        m_scl = 1'b1; wait_scl_high(); tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(8);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(8);
        m_scl = 1'b1; wait_scl_high(); tick(8);
        m_sda = 1'b1; tick(16);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            d = {d[6:0], b};
        end
        send_bit(~mack);
    endtask

    initial begin
        logic       ack;
        logic [7:0] rd;
        logic [6:0] a;
        logic [7:0] exp_d;
        int         we_before;

        tick(2);
        chk("R1 drive in reset", sda_drive_low, 0);
        chk("R1 hold in reset", scl_hold_low, 0);
        tick(8);
        rst_n = 1'b1;
        tick(4);
        chk("R1 drive after reset", sda_drive_low, 0);
        chk("R1 hold after reset", scl_hold_low, 0);
        chk("R1 we after reset", rf_we, 0);

        // Vector table: write three bytes, then read them back
        for (int v = 0; v < 4; v++) begin
            we_before = we_count;
            bus_start();
            write_byte({ADDR, 1'b0}, ack); chk("R2 address ack", ack, 1);
            write_byte(VEC[v].sub, ack);   chk("R3 sub-address ack", ack, 1);
            write_byte(VEC[v].d0, ack);    chk("R4 data ack", ack, 1);
            write_byte(VEC[v].d1, ack);    chk("R4 data ack", ack, 1);
            write_byte(VEC[v].d2, ack);    chk("R4 data ack", ack, 1);
            bus_stop();
            chk("R4 write strobes", we_count - we_before, 3);
            for (int k = 0; k < 3; k++) begin
                a = VEC[v].sub[6:0] + (VEC[v].sub[7] ? 7'(k) : 7'd0);
                exp_d = (k == 0) ? VEC[v].d0 : (k == 1) ? VEC[v].d1 : VEC[v].d2;
                if (VEC[v].sub[7]) chk("R6 written register", mem[a], exp_d);
                else if (k == 2) chk("R7 single register", mem[a], exp_d);
            end

            bus_start();
            write_byte({ADDR, 1'b0}, ack); chk("R2 address ack", ack, 1);
            write_byte(VEC[v].sub, ack);   chk("R3 sub-address ack", ack, 1);
            bus_rstart();
            write_byte({ADDR, 1'b1}, ack); chk("R5 read address ack", ack, 1);
            for (int k = 0; k < 3; k++) begin
                read_byte(rd, k != 2);
                exp_d = !VEC[v].sub[7] ? VEC[v].d2 :
                        (k == 0) ? VEC[v].d0 : (k == 1) ? VEC[v].d1 : VEC[v].d2;
                chk(VEC[v].sub[7] ? "R6 read byte" : "R7 read byte", rd, exp_d);
            end
            chk("R8 released after nack", sda_drive_low, 0);
            bus_stop();
        end

        // R2: wrong address is not acknowledged and writes nothing
        we_before = we_count;
        bus_start();
        write_byte({ADDR ^ 7'h01, 1'b0}, ack); chk("R2 mismatch nack", ack, 0);
        write_byte(8'h05, ack);                chk("R2 ignored byte nack", ack, 0);
        write_byte(8'hEE, ack);
        bus_stop();
        chk("R2 no strobe on mismatch", we_count - we_before, 0);
        chk("R2 register untouched", mem[5], 8'h11);

        // R11: repeated start inside a write
        bus_start();
        write_byte({ADDR, 1'b0}, ack);
        write_byte(8'hB0, ack);
        write_byte(8'h12, ack);
        bus_rstart();
        write_byte({ADDR, 1'b0}, ack); chk("R11 address after rstart", ack, 1);
        write_byte(8'h40, ack);
        write_byte(8'h34, ack);
        bus_stop();
        chk("R11 first part", mem[8'h30], 8'h12);
        chk("R11 second part", mem[8'h40], 8'h34);
        chk("R11 no stray advance", mem[8'h31], 8'h00);

        // R10: clock stretching while busy
        bus_start();
        write_byte({ADDR, 1'b0}, ack);
        write_byte(8'h50, ack);
        busy = 1'b1;
        fork
            write_byte(8'h77, ack);
            begin
                tick(300);
                chk("R10 hold asserted", scl_hold_low, 1);
                chk("R10 SCL held low", scl_bus, 0);
                busy = 1'b0;
            end
        join
        chk("R10 ack after stretch", ack, 1);
        tick(4);
        chk("R10 hold released", scl_hold_low, 0);
        bus_stop();
        chk("R10 data after stretch", mem[8'h50], 8'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule